// File: doc/BRIEF.md
# Supply-Voltage Monitor Reset Sequencer

This block is the digital controller that sits beside an analog supply comparator. It runs from a free-running low-speed oscillator clock. It drives an active-low internal reset that is asserted whenever the comparator reports the supply at or below the selected threshold. The reset is released only after the supply has stayed good for a fixed number of oscillator cycles. It also passes a two-bit threshold select to the analog detector. While reset is asserted, it forces the CPU clock onto the undivided low-speed oscillator.

The threshold select and a monitor-disable flag come from a non-volatile option byte. That byte is captured once after the external power-on reset and cannot be altered from the CPU bus afterwards. When the flag disables the monitor, the internal reset follows only the external power-on reset. This reset leaves on-chip RAM untouched, so the block has no RAM-clear output.

The control is a four-state machine:
- ST_HOLD keeps reset asserted. It moves to ST_COUNT on "supply good" and to ST_BYPASS on "monitor disabled".
- ST_COUNT counts good cycles. It moves to ST_RUN on "count done" and back to ST_HOLD on "supply lost".
- ST_RUN has reset released. It returns to ST_HOLD on "supply lost".
- ST_BYPASS has reset released and is left only through the external power-on reset.

The external power-on reset forces ST_HOLD from every state.

Top module: `vmon_rst_seq`

## Requirements
- R1: While por_n is low, sys_rst_n is 0, cpu_clk_force is 1 and det_lvl_sel is 00, with no clock edge needed.
- R2: The first opt_load pulse after por_n rises captures opt_byte. Bit 4 goes to det_lvl_sel[0], bit 5 goes to det_lvl_sel[1], and bit 6 is the monitor-disable flag, where 0 enables the monitor. Later opt_load pulses have no effect until the next por_n assertion.
- R3: cpu_wr_en with any cpu_wr_data changes neither det_lvl_sel nor sys_rst_n.
- R4: With the monitor enabled, sys_rst_n stays 0 while the option byte is not yet captured or while the synchronized comparator reads low.
- R5: With the monitor enabled and the option captured, suppose det_ok rises between clock edges and stays high. Then sys_rst_n rises after exactly SYNC_STAGES+1+RELEASE_CNT edges, which is 35 with the defaults.
- R6: When det_ok falls while the reset is released, sys_rst_n falls after exactly SYNC_STAGES+1 edges (3).
- R7: Suppose det_ok is high for k edges and then falls. If k is at most RELEASE_CNT, sys_rst_n never rises and the count restarts from zero on the next recovery. Otherwise sys_rst_n is high for exactly k-RELEASE_CNT samples.
- R8: With the disable flag (bit 6) set, sys_rst_n is 1 after capture, whatever det_ok does, and falls at once when por_n falls.
- R9: cpu_clk_force is 1, meaning the CPU is forced onto the undivided low-speed clock, exactly when sys_rst_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Free-running low-speed oscillator clock |
| por_n | input | 1 | External power-on reset, active low, asynchronous |
| det_ok | input | 1 | Asynchronous comparator output, 1 = supply at or above threshold |
| opt_load | input | 1 | Strobe that captures the option byte from non-volatile storage |
| opt_byte | input | 8 | Option byte (bit 6 disable, bits 5:4 threshold select) |
| cpu_wr_en | input | 1 | CPU bus write strobe to the option location (ignored) |
| cpu_wr_data | input | 8 | CPU bus write data (ignored) |
| sys_rst_n | output | 1 | Internal reset, active low |
| det_lvl_sel | output | 2 | Threshold select driven to the analog detector |
| cpu_clk_force | output | 1 | Forces the CPU clock to the undivided low-speed oscillator |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES of 2 and RELEASE_CNT of 32. With these values one release takes 35 edges, so a sweep of every drop offset from 1 to 40 cycles fits easily in the run time. The sweep covers every counter value on both sides of the release point, including the two offsets where the synchronizer lag lets the release slip out before the drop is seen. A second power-on cycle with the disable flag set reaches the bypass state.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_RUN    = 2'd2,
        ST_BYPASS = 2'd3
    } vmon_state_e;

    localparam int OPT_LVL_LSB = 4;
    localparam int OPT_LVL_W   = 2;
    localparam int OPT_DIS_BIT = 6;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) r <= 1'b0;
                else         r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/vmon_optreg.sv
module vmon_optreg
    import vmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 arst_n,
    input  logic                 load,
    input  logic [7:0]           opt_in,
    output logic                 loaded,
    output logic [OPT_LVL_W-1:0] lvl_sel,
    output logic                 mon_dis
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            loaded  <= 1'b0;
            lvl_sel <= '0;
            mon_dis <= 1'b0;
        end else if (load && !loaded) begin
            loaded  <= 1'b1;
            lvl_sel <= opt_in[OPT_LVL_LSB +: OPT_LVL_W];
            mon_dis <= opt_in[OPT_DIS_BIT];
        end
    end
endmodule

// File: rtl/vmon_fsm.sv
module vmon_fsm
    import vmon_pkg::*;
#(
    parameter int RELEASE_CNT = 32,
    localparam int CW = (RELEASE_CNT > 1) ? $clog2(RELEASE_CNT) : 1
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        mon_en,
    input  logic        mon_byp,
    input  logic        det_s,
    output vmon_state_e state,
    output logic [CW-1:0] cnt,
    output logic        rst_out_n,
    output logic        clk_force
);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CNT - 1);

    vmon_state_e   nxt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = '0;
        unique case (state)
            ST_HOLD: begin
                if (mon_byp)              nxt = ST_BYPASS;
                else if (mon_en && det_s) nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (!det_s)            nxt = ST_HOLD;
                else if (cnt == LAST)  nxt = ST_RUN;
                else                   cnt_nxt = cnt + 1'b1;
            end
            ST_RUN: begin
                if (!det_s) nxt = ST_HOLD;
            end
            ST_BYPASS: begin
                nxt = ST_BYPASS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN, ST_BYPASS: begin
                rst_out_n = 1'b1;
                clk_force = 1'b0;
            end
            default: begin
                rst_out_n = 1'b0;
                clk_force = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vmon_rst_seq.sv
module vmon_rst_seq
    import vmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RELEASE_CNT = 32
) (
    input  logic       clk_lo,
    input  logic       por_n,
    input  logic       det_ok,
    input  logic       opt_load,
    input  logic [7:0] opt_byte,
    input  logic       cpu_wr_en,
    input  logic [7:0] cpu_wr_data,
    output logic       sys_rst_n,
    output logic [1:0] det_lvl_sel,
    output logic       cpu_clk_force
);
    localparam int CW = (RELEASE_CNT > 1) ? $clog2(RELEASE_CNT) : 1;

    logic          det_s;
    logic          opt_loaded;
    logic          mon_dis;
    logic          mon_en;
    logic          mon_byp;
    vmon_state_e   state;
    logic [CW-1:0] cnt;

    // Option bits are read-only to software: the bus write port reaches nothing.
    logic unused_cpu_bus;
    assign unused_cpu_bus = ^{cpu_wr_en, cpu_wr_data};

    vmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk_lo),
        .arst_n (por_n),
        .d      (det_ok),
        .q      (det_s)
    );

    vmon_optreg i_opt (
        .clk     (clk_lo),
        .arst_n  (por_n),
        .load    (opt_load),
        .opt_in  (opt_byte),
        .loaded  (opt_loaded),
        .lvl_sel (det_lvl_sel),
        .mon_dis (mon_dis)
    );

    assign mon_en  = opt_loaded && !mon_dis;
    assign mon_byp = opt_loaded &&  mon_dis;

    vmon_fsm #(.RELEASE_CNT(RELEASE_CNT)) i_fsm (
        .clk       (clk_lo),
        .arst_n    (por_n),
        .mon_en    (mon_en),
        .mon_byp   (mon_byp),
        .det_s     (det_s),
        .state     (state),
        .cnt       (cnt),
        .rst_out_n (sys_rst_n),
        .clk_force (cpu_clk_force)
    );
endmodule

// File: rtl/vmon_rst_seq_chk.sv
module vmon_rst_seq_chk #(
    parameter int RELEASE_CNT = 32,
    localparam int CW = (RELEASE_CNT > 1) ? $clog2(RELEASE_CNT) : 1
) (
    input logic          clk,
    input logic          por_n,
    input logic          rst_n,
    input logic          clk_force,
    input logic [1:0]    lvl_sel,
    input logic          loaded,
    input logic          mon_dis,
    input logic          det_s,
    input logic [CW-1:0] cnt
);
    assert_por_clears_R1: assert property (@(posedge clk)
        !por_n |-> (!rst_n && clk_force && lvl_sel == 2'b00));

    assert_opt_frozen_R2: assert property (@(posedge clk) disable iff (!por_n)
        (loaded && $past(loaded)) |-> $stable(lvl_sel));

    assert_hold_unloaded_R4: assert property (@(posedge clk) disable iff (!por_n)
        !loaded |-> !rst_n);

    assert_low_supply_resets_R4: assert property (@(posedge clk) disable iff (!por_n)
        (loaded && !mon_dis && !det_s) |=> !rst_n);

    assert_release_after_count_R5: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(rst_n) && !mon_dis) |-> ($past(cnt) == CW'(RELEASE_CNT - 1)));

    assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!por_n)
        (loaded && mon_dis) |=> (cnt == '0 && rst_n));

    assert_clk_force_R9: assert property (@(posedge clk) disable iff (!por_n)
        clk_force == !rst_n);
endmodule

bind vmon_rst_seq vmon_rst_seq_chk #(.RELEASE_CNT(RELEASE_CNT)) i_chk (
    .clk       (clk_lo),
    .por_n     (por_n),
    .rst_n     (sys_rst_n),
    .clk_force (cpu_clk_force),
    .lvl_sel   (det_lvl_sel),
    .loaded    (opt_loaded),
    .mon_dis   (mon_dis),
    .det_s     (det_s),
    .cnt       (cnt)
);

// File: tb/test_vmon_rst_seq.sv
`timescale 1ns/1ps
module test_vmon_rst_seq;
    localparam int SYNC = 2;
    localparam int REL  = 32;
    localparam int LAT  = SYNC + 1 + REL;

    logic clk = 1'b0;
    logic por_n, det_ok, opt_load, cpu_wr_en;
    logic [7:0] opt_byte, cpu_wr_data;
    logic sys_rst_n, cpu_clk_force;
    logic [1:0] det_lvl_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vmon_rst_seq #(.SYNC_STAGES(SYNC), .RELEASE_CNT(REL)) i_vmon_rst_seq (
        .clk_lo(clk), .por_n(por_n), .det_ok(det_ok), .opt_load(opt_load),
        .opt_byte(opt_byte), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .sys_rst_n(sys_rst_n), .det_lvl_sel(det_lvl_sel), .cpu_clk_force(cpu_clk_force)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load_opt(input logic [7:0] b);
        opt_byte = b;
        opt_load = 1'b1;
        tick(1);
        opt_load = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        int high;
        bit force_ok;
        por_n = 1'b0; det_ok = 1'b0; opt_load = 1'b0; opt_byte = 8'h00;
        cpu_wr_en = 1'b0; cpu_wr_data = 8'h00;
        tick(3);
        // R1 reset state
        chk(sys_rst_n == 1'b0, "R1 rst_n", sys_rst_n, 0);
        chk(cpu_clk_force == 1'b1, "R1 clk_force", cpu_clk_force, 1);
        chk(det_lvl_sel == 2'b00, "R1 lvl_sel", det_lvl_sel, 0);

        por_n = 1'b1;
        det_ok = 1'b1;
        tick(50);
        // R4 option not captured: reset held even with good supply
        chk(sys_rst_n == 1'b0, "R4 unloaded", sys_rst_n, 0);

        // R2 capture: bit5=1 bit4=0 -> lvl 10, bit6=0 enabled, other bits noise
        load_opt(8'b1010_1111);
        cnt = 0;
        while (!sys_rst_n && cnt < 60) begin tick(1); cnt++; end
        chk(sys_rst_n == 1'b1, "R2 enabled release", sys_rst_n, 1);
        chk(det_lvl_sel == 2'b10, "R2 lvl capture", det_lvl_sel, 2);
        load_opt(8'b0101_0000);
        tick(3);
        chk(det_lvl_sel == 2'b10, "R2 second load ignored", det_lvl_sel, 2);
        chk(sys_rst_n == 1'b1, "R2 second load keeps monitor", sys_rst_n, 1);

        // R3 CPU writes of every value ignored
        for (int v = 0; v < 256; v++) begin
            cpu_wr_en = 1'b1;
            cpu_wr_data = 8'(v);
            tick(1);
        end
        cpu_wr_en = 1'b0;
        tick(2);
        chk(det_lvl_sel == 2'b10, "R3 lvl after writes", det_lvl_sel, 2);
        chk(sys_rst_n == 1'b1, "R3 rst after writes", sys_rst_n, 1);

        // R6 supply drop latency
        det_ok = 1'b0;
        cnt = 0;
        while (sys_rst_n && cnt < 20) begin tick(1); cnt++; end
        chk(cnt == SYNC + 1, "R6 drop latency", cnt, SYNC + 1);
        chk(cpu_clk_force == 1'b1, "R9 force on drop", cpu_clk_force, 1);
        tick(5);

        // R5 release latency
        det_ok = 1'b1;
        cnt = 0;
        while (!sys_rst_n && cnt < 100) begin tick(1); cnt++; end
        chk(cnt == LAT, "R5 release latency", cnt, LAT);
        chk(cpu_clk_force == 1'b0, "R9 force off on release", cpu_clk_force, 0);
        det_ok = 1'b0;
        tick(6);

        // R7 sweep of drop offsets during and after the count
        for (int k = 1; k <= 40; k++) begin
            high = 0;
            force_ok = 1'b1;
            det_ok = 1'b1;
            for (int i = 0; i < k; i++) begin
                tick(1);
                if (sys_rst_n) high++;
                if (cpu_clk_force != !sys_rst_n) force_ok = 1'b0;
            end
            det_ok = 1'b0;
            for (int i = 0; i < 6; i++) begin
                tick(1);
                if (sys_rst_n) high++;
                if (cpu_clk_force != !sys_rst_n) force_ok = 1'b0;
            end
            chk(high == ((k > REL) ? k - REL : 0), "R7 high samples", high,
                (k > REL) ? k - REL : 0);
            chk(force_ok, "R9 force tracks reset", force_ok, 1);
        end
        chk(sys_rst_n == 1'b0, "R7 held after sweep", sys_rst_n, 0);

        // R7 restart from zero after an aborted count
        det_ok = 1'b1;
        cnt = 0;
        while (!sys_rst_n && cnt < 100) begin tick(1); cnt++; end
        chk(cnt == LAT, "R7 full restart", cnt, LAT);

        // R8 bypass via disable flag, bit6=1 bit4=1 -> lvl 01
        por_n = 1'b0;
        tick(2);
        chk(sys_rst_n == 1'b0, "R1 por again", sys_rst_n, 0);
        chk(det_lvl_sel == 2'b00, "R1 lvl cleared", det_lvl_sel, 0);
        por_n = 1'b1;
        det_ok = 1'b0;
        load_opt(8'b0101_0000);
        tick(2);
        chk(sys_rst_n == 1'b1, "R8 bypass release", sys_rst_n, 1);
        chk(det_lvl_sel == 2'b01, "R2 lvl bypass capture", det_lvl_sel, 1);
        force_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            det_ok = i[2];
            tick(1);
            if (!sys_rst_n || cpu_clk_force) force_ok = 1'b0;
        end
        chk(force_ok, "R8 det ignored in bypass", force_ok, 1);
        por_n = 1'b0;
        #1;
        chk(sys_rst_n == 1'b0, "R8 follows por", sys_rst_n, 0);
        chk(cpu_clk_force == 1'b1, "R9 force on por", cpu_clk_force, 1);
        tick(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule